// File: doc/BRIEF.md
# Snooping Line Coherence Engine

This block keeps the coherence state of a single cache line for up to four cores that share one snooping bus. Each cycle it can accept one access event, which is a read or a write together with the index of the core that makes it. It works out which bus transaction the requesting core must issue. It then moves the requester and every snooping copy to their new states at the same clock edge.

A run-time mode input chooses between the four-state protocol (MESI) and the five-state protocol (MOESI). In the five-state protocol, a dirty line that another core reads stays dirty in its holder, which then owns it. The block reports these outputs:
- the state of every core's copy;
- the transaction issued for the last accepted event;
- which cache, if any, supplies the data;
- a running count of bus messages;
- a running count of copies destroyed by invalidation.

An event whose core index is out of range is refused with an error flag and changes nothing.

Top module: `coh_line_engine`

## Requirements
- R1: After reset every core's copy is Invalid, both counters are zero, the bus field shows no transaction and the error flag is low. Each core k has a 3-bit code in `lineState[3k+2:3k]`: Invalid=0, Shared=1, Exclusive=2, Modified=3, Owned=4.
- R2: A read by a core whose copy is Invalid issues a bus read (`busOp`=1). The requester becomes Exclusive when no other copy is valid, and Shared otherwise.
- R3: On a bus read, another core in Modified drops to Shared in MESI mode (`moesiMode`=0) and to Owned in MOESI mode (`moesiMode`=1). Another core in Exclusive drops to Shared. Shared and Owned copies keep their state.
- R4: On a bus read or a bus read-for-ownership, a core other than the requester that holds the line in Modified or Owned is reported through `supplyValid`=1 and its index on `supplyCore`. In every other case `supplyValid` is 0.
- R5: A write by a core in Invalid or Shared issues a bus read-for-ownership (`busOp`=2). Every other copy becomes Invalid and the requester becomes Modified.
- R6: A write by a core in Owned issues an invalidate (`busOp`=3). Every other copy becomes Invalid and the requester becomes Modified.
- R7: A read that hits in Shared, Exclusive, Modified or Owned issues no transaction (`busOp`=0) and changes no state. A write in Exclusive or Modified also issues no transaction and leaves the requester in Modified.
- R8: `msgCount` rises by one for each transaction issued. `invCount` rises by the number of other valid copies destroyed by a read-for-ownership or an invalidate.
- R9: An event whose core index is not below NUM_CORES sets `errFlag` for one cycle, shows `busOp`=0, and leaves all states and both counters unchanged.
- R10: At any time at most one core is in Modified, and a Modified copy is the only valid copy.
- R11: `evtReady` is high in every cycle after reset. In a cycle with no accepted event, the next cycle shows `busOp`=0, `supplyValid`=0 and `errFlag`=0, and no state changes.
- R12: `busOp`, `supplyValid`, `supplyCore` and `errFlag` describe the event accepted at the preceding clock edge. The new states and counts appear on the outputs from that same edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | An access event is presented |
| evtReady | output | 1 | The engine accepts an event this cycle |
| evtWrite | input | 1 | 1 = write, 0 = read |
| evtCore | input | IDX_W (3) | Index of the requesting core |
| moesiMode | input | 1 | 0 = MESI rules, 1 = MOESI rules |
| lineState | output | 3*NUM_CORES (12) | Packed per-core state codes |
| busOp | output | 2 | Transaction of the last event: 0 none, 1 read, 2 read-for-ownership, 3 invalidate |
| supplyValid | output | 1 | A cache supplied the data for the last transaction |
| supplyCore | output | CORE_W (2) | Index of the supplying cache |
| errFlag | output | 1 | The last event carried an out-of-range core index |
| msgCount | output | CNT_W (16) | Bus transactions issued since reset |
| invCount | output | CNT_W (16) | Copies invalidated since reset |

## Verification
The assertions check the single-writer rule and the rule that a Modified copy is alone on every cycle. They also check on every cycle that the message counter moves by one exactly when a transaction is shown, that a refused event leaves the states intact, that a supplier appears only with a read transaction, and that the engine stays ready. Only the bench's scenarios can show that the right transitions happen. The bench drives a scripted MESI trace, the MESI/MOESI Owned hand-offs and the Owned-write invalidate, followed by a long random event mix. For each event it compares the exact next states, the chosen supplier and the invalidation amounts with an independent model.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_M = 3'd3,
    ST_O = 3'd4
  } cohState_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_RDX  = 2'd2,
    OP_INV  = 2'd3
  } busOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   take;     // legal event accepted this cycle
    logic   err;      // event refused (bad index)
    logic   isWrite;
    busOp_e op;
  } cohStrobe_t;

endpackage

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 3,
  localparam int ST_W     = 3 * NUM_CORES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evtValid,
  input  logic                 evtWrite,
  input  logic [IDX_W-1:0]     evtCore,
  input  logic [ST_W-1:0]      lineState,
  output logic                 evtReady,
  output cohStrobe_t           strb,
  output logic [NUM_CORES-1:0] reqMask
);

  logic      readyQ;
  logic      inRange;
  logic      take;
  cohState_e reqState;
  busOp_e    opSel;

  always_ff @(posedge clk) begin
    if (!rst_n) readyQ <= 1'b0;
    else        readyQ <= 1'b1;
  end
  assign evtReady = readyQ;

  assign take    = evtValid && readyQ;
  assign inRange = (32'(evtCore) < NUM_CORES);

  always_comb begin
    reqState = ST_I;
    reqMask  = '0;
    for (int k = 0; k < NUM_CORES; k++) begin
      if (inRange && (32'(evtCore) == k)) begin
        reqState   = cohState_e'(lineState[k*3 +: 3]);
        reqMask[k] = 1'b1;
      end
    end
  end

  always_comb begin
    opSel = OP_NONE;
    if (evtWrite) begin
      unique case (reqState)
        ST_I, ST_S: opSel = OP_RDX;
        ST_O:       opSel = OP_INV;
        default:    opSel = OP_NONE;
      endcase
    end else if (reqState == ST_I) begin
      opSel = OP_RD;
    end
  end

  always_comb begin
    strb.take    = take && inRange;
    strb.err     = take && !inRange;
    strb.isWrite = evtWrite;
    strb.op      = (take && inRange) ? opSel : OP_NONE;
  end

endmodule

// File: rtl/coh_datapath.sv
module coh_datapath
  import coh_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 16,
  localparam int ST_W     = 3 * NUM_CORES,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cohStrobe_t           strb,
  input  logic [NUM_CORES-1:0] reqMask,
  input  logic                 moesiMode,
  output logic [ST_W-1:0]      lineState,
  output logic [1:0]           busOp,
  output logic                 supplyValid,
  output logic [CORE_W-1:0]    supplyCore,
  output logic                 errFlag,
  output logic [CNT_W-1:0]     msgCount,
  output logic [CNT_W-1:0]     invCount
);

  cohState_e            stQ [NUM_CORES];
  logic [NUM_CORES-1:0] validVec;
  logic [NUM_CORES-1:0] otherValid;
  logic                 anyOther;
  logic                 supNext;
  logic [CORE_W-1:0]    supIdx;
  logic [CNT_W-1:0]     invInc;
  logic                 killOthers;

  assign killOthers = (strb.op == OP_RDX) || (strb.op == OP_INV);

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    cohState_e nextSt;

    assign validVec[k]        = (stQ[k] != ST_I);
    assign lineState[k*3 +: 3] = stQ[k];

    always_comb begin
      nextSt = stQ[k];
      if (strb.take) begin
        if (reqMask[k]) begin
          if (strb.isWrite)       nextSt = ST_M;
          else if (stQ[k] == ST_I) nextSt = anyOther ? ST_S : ST_E;
        end else if (killOthers) begin
          nextSt = ST_I;
        end else if (strb.op == OP_RD) begin
          if (stQ[k] == ST_M)      nextSt = moesiMode ? ST_O : ST_S;
          else if (stQ[k] == ST_E) nextSt = ST_S;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) stQ[k] <= ST_I;
      else        stQ[k] <= nextSt;
    end
  end

  assign otherValid = validVec & ~reqMask;
  assign anyOther   = |otherValid;

  // dirty holder other than the requester supplies data
  always_comb begin
    supNext = 1'b0;
    supIdx  = '0;
    for (int k = NUM_CORES - 1; k >= 0; k--) begin
      if (!reqMask[k] && (stQ[k] == ST_M || stQ[k] == ST_O)) begin
        supNext = (strb.op == OP_RD) || (strb.op == OP_RDX);
        supIdx  = CORE_W'(k);
      end
    end
  end

  always_comb begin
    invInc = '0;
    for (int k = 0; k < NUM_CORES; k++)
      invInc = invInc + CNT_W'(otherValid[k]);
    if (!killOthers) invInc = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busOp       <= OP_NONE;
      supplyValid <= 1'b0;
      supplyCore  <= '0;
      errFlag     <= 1'b0;
      msgCount    <= '0;
      invCount    <= '0;
    end else begin
      busOp       <= strb.op;
      supplyValid <= supNext;
      supplyCore  <= supNext ? supIdx : '0;
      errFlag     <= strb.err;
      if (strb.op != OP_NONE) msgCount <= msgCount + 1'b1;
      invCount    <= invCount + invInc;
    end
  end

endmodule

// File: rtl/coh_line_engine.sv
module coh_line_engine
  import coh_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 16,
  localparam int ST_W     = 3 * NUM_CORES,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evtValid,
  output logic              evtReady,
  input  logic              evtWrite,
  input  logic [IDX_W-1:0]  evtCore,
  input  logic              moesiMode,
  output logic [ST_W-1:0]   lineState,
  output logic [1:0]        busOp,
  output logic              supplyValid,
  output logic [CORE_W-1:0] supplyCore,
  output logic              errFlag,
  output logic [CNT_W-1:0]  msgCount,
  output logic [CNT_W-1:0]  invCount
);

  cohStrobe_t           strb;
  logic [NUM_CORES-1:0] reqMask;

  coh_ctrl #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evtValid  (evtValid),
    .evtWrite  (evtWrite),
    .evtCore   (evtCore),
    .lineState (lineState),
    .evtReady  (evtReady),
    .strb      (strb),
    .reqMask   (reqMask)
  );

  coh_datapath #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .reqMask     (reqMask),
    .moesiMode   (moesiMode),
    .lineState   (lineState),
    .busOp       (busOp),
    .supplyValid (supplyValid),
    .supplyCore  (supplyCore),
    .errFlag     (errFlag),
    .msgCount    (msgCount),
    .invCount    (invCount)
  );

endmodule

// File: rtl/coh_line_engine_chk.sv
module coh_line_engine_chk #(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 16,
  localparam int ST_W     = 3 * NUM_CORES,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evtValid,
  input logic              evtReady,
  input logic              evtWrite,
  input logic [IDX_W-1:0]  evtCore,
  input logic              moesiMode,
  input logic [ST_W-1:0]   lineState,
  input logic [1:0]        busOp,
  input logic              supplyValid,
  input logic [CORE_W-1:0] supplyCore,
  input logic              errFlag,
  input logic [CNT_W-1:0]  msgCount,
  input logic [CNT_W-1:0]  invCount
);

  logic [NUM_CORES-1:0] isM;
  logic [NUM_CORES-1:0] isValid;

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_dec
    assign isM[k]     = (lineState[k*3 +: 3] == 3'd3);
    assign isValid[k] = (lineState[k*3 +: 3] != 3'd0);
  end

  // R10
  single_modified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isM));

  // R10
  modified_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|isM) |-> ($countones(isValid) == 1));

  // R9
  refused_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |-> (lineState == $past(lineState) && msgCount == $past(msgCount)
                 && busOp == 2'd0));

  // R8
  msg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busOp != 2'd0) |-> (msgCount == $past(msgCount) + 1'b1));

  // R8
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busOp == 2'd0) |-> $stable(msgCount));

  // R4
  supply_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supplyValid |-> (busOp == 2'd1 || busOp == 2'd2));

  // R11
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> evtReady);

endmodule

bind coh_line_engine coh_line_engine_chk #(
  .NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .CNT_W(CNT_W)
) chk_i (.*);

// File: tb/coh_line_engine_tb_top.sv
module coh_line_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NC         = 4;
  localparam int IW         = 3;
  localparam int CW         = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          evtValid = 1'b0;
  logic          evtReady;
  logic          evtWrite = 1'b0;
  logic [IW-1:0] evtCore = '0;
  logic          moesiMode = 1'b0;
  logic [3*NC-1:0] lineState;
  logic [1:0]    busOp;
  logic          supplyValid;
  logic [1:0]    supplyCore;
  logic          errFlag;
  logic [CW-1:0] msgCount;
  logic [CW-1:0] invCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_line_engine #(.NUM_CORES(NC), .IDX_W(IW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .evtValid(evtValid), .evtReady(evtReady),
    .evtWrite(evtWrite), .evtCore(evtCore), .moesiMode(moesiMode),
    .lineState(lineState), .busOp(busOp), .supplyValid(supplyValid),
    .supplyCore(supplyCore), .errFlag(errFlag), .msgCount(msgCount),
    .invCount(invCount)
  );

  typedef struct {
    logic [3*NC-1:0] st;
    logic [1:0]      op;
    logic            sv;
    logic [1:0]      sc;
    logic            err;
    logic [CW-1:0]   msg;
    logic [CW-1:0]   inv;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  int       nChecks = 0;
  int       nFails  = 0;
  int       refSt[NC];
  int       refMsg = 0;
  int       refInv = 0;
  logic     acceptSeen = 1'b0;

  // codes: I=0 S=1 E=2 M=3 O=4
  function automatic logic [3*NC-1:0] packRef();
    logic [3*NC-1:0] v;
    for (int k = 0; k < NC; k++) v[k*3 +: 3] = 3'(refSt[k]);
    return v;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: compute expectation from the requirements, then present event
  task automatic applyEvt(input bit wr, input int core, input bit moesi);
    expItem_t e;
    string    tag;
    int       s, anyOther, sup, hadDirty;
    e.sv = 1'b0; e.sc = '0; e.err = 1'b0; e.op = 2'd0;
    if (core >= NC) begin
      e.err = 1'b1; tag = "R9";
    end else begin
      s = refSt[core]; anyOther = 0; sup = -1; hadDirty = 0;
      for (int k = 0; k < NC; k++) if (k != core) begin
        if (refSt[k] != 0) anyOther++;
        if ((refSt[k] == 3 || refSt[k] == 4) && sup < 0) sup = k;
        if (refSt[k] == 3) hadDirty = 1;
      end
      if (!wr) begin
        if (s == 0) begin
          e.op = 2'd1; tag = hadDirty ? "R3" : "R2";
          if (sup >= 0) begin e.sv = 1'b1; e.sc = 2'(sup); end
          for (int k = 0; k < NC; k++) if (k != core) begin
            if (refSt[k] == 3) refSt[k] = moesi ? 4 : 1;
            else if (refSt[k] == 2) refSt[k] = 1;
          end
          refSt[core] = (anyOther > 0) ? 1 : 2;
        end else tag = "R7";
      end else begin
        if (s == 0 || s == 1 || s == 4) begin
          e.op = (s == 4) ? 2'd3 : 2'd2; tag = (s == 4) ? "R6" : "R5";
          if (s != 4 && sup >= 0) begin e.sv = 1'b1; e.sc = 2'(sup); end
          refInv += anyOther;
          for (int k = 0; k < NC; k++) if (k != core) refSt[k] = 0;
        end else tag = "R7";
        refSt[core] = 3;
      end
      if (e.op != 2'd0) refMsg++;
    end
    e.st = packRef(); e.msg = CW'(refMsg); e.inv = CW'(refInv);
    @(negedge clk);
    evtValid = 1'b1; evtWrite = wr; evtCore = IW'(core); moesiMode = moesi;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    evtValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) acceptSeen <= evtValid && evtReady && rst_n;

  // monitor: outputs of the event accepted at the previous edge (R12)
  always @(negedge clk) begin
    if (acceptSeen && expQ.size() > 0) begin
      expItem_t e;
      string    t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, "lineState", 32'(lineState), 32'(e.st));
      check(t, "busOp(R12)", 32'(busOp), 32'(e.op));
      check("R4", "supplyValid", 32'(supplyValid), 32'(e.sv));
      if (e.sv) check("R4", "supplyCore", 32'(supplyCore), 32'(e.sc));
      check("R9", "errFlag", 32'(errFlag), 32'(e.err));
      check("R8", "msgCount", 32'(msgCount), 32'(e.msg));
      check("R8", "invCount", 32'(invCount), 32'(e.inv));
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int k = 0; k < NC; k++) refSt[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "lineState", 32'(lineState), 32'd0);
    check("R1", "msgCount", 32'(msgCount), 32'd0);
    check("R1", "invCount", 32'(invCount), 32'd0);
    check("R1", "busOp", 32'(busOp), 32'd0);
    check("R1", "errFlag", 32'(errFlag), 32'd0);
    check("R11", "evtReady", 32'(evtReady), 32'd1);

    // MESI trace: read/write by core0, read/write by core1
    applyEvt(0, 0, 0); applyEvt(1, 0, 0);
    applyEvt(0, 1, 0); applyEvt(1, 1, 0);
    applyEvt(0, 2, 0); applyEvt(0, 3, 0);
    applyEvt(1, 3, 0);                     // R5 from Shared, two killed
    applyEvt(0, 5, 0);                     // R9 bad index
    applyEvt(0, 3, 0); applyEvt(1, 3, 0);  // R7 hits in Modified
    idle(2);
    // R11 idle cycles
    check("R11", "busOp idle", 32'(busOp), 32'd0);
    check("R11", "supplyValid idle", 32'(supplyValid), 32'd0);
    check("R11", "errFlag idle", 32'(errFlag), 32'd0);
    check("R11", "lineState idle", 32'(lineState), 32'(packRef()));

    // MOESI: Modified becomes Owned and keeps supplying
    applyEvt(0, 0, 1); applyEvt(0, 1, 1);
    applyEvt(1, 3, 1);                     // R6 Owned write invalidate
    applyEvt(1, 0, 1);                     // R5 from Invalid, supplier core3
    applyEvt(0, 2, 1); applyEvt(1, 2, 1);  // RDX from Shared with Owned holder
    applyEvt(0, 7, 1);                     // R9
    idle(1);

    // random mix in both modes
    for (int i = 0; i < 600; i++) begin
      int c;
      c = ($urandom % 9 == 0) ? 4 + int'($urandom % 4) : int'($urandom % NC);
      applyEvt(1'($urandom), c, 1'($urandom));
      if ($urandom % 7 == 0) idle(1);
    end
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule